// File: doc/BRIEF.md
# Ten-Phase Instruction Sequencer

This block is the control unit of a small 8-bit processor. It puts the program counter on the address bus, takes one 16-bit instruction word from program memory in a single fetch, decodes it, and then walks the same ten-phase schedule for every instruction. Along the way it raises register-file read enables and operand selects, starts the external ALU, latches the ALU's flags and result, writes register destinations, and finally advances or reloads the program counter. The register storage, the ALU datapath and the program memory all sit outside the block. They are reached through select, enable and data ports.

Instructions come in two classes. A move-class word loads an 8-bit immediate into any of eight destinations. Destination 7 is the program counter, so a jump is just a move aimed at it. A call is a move that also saves the return address in the link register (destination 6). Conditional moves and calls test the zero or negative flag, or the inverse of zero. An ALU-class word names two sources, an operation and a destination. It carries a bit that keeps the flags update but drops the register write, so any operation can serve as a compare.

Top module: `seq_core`

## Requirements
- R1: The phase output counts 0,1,...,9 and wraps to 0, one instruction per ten cycles. memAddr shows the program counter and changes only at the edge that leaves phase 9. The word on memData is taken as the instruction at the edge that leaves phase 0.
- R2: A synchronous reset clears phase, program counter and flags to zero. While reset is held, wrEn, rdEn and aluGo stay low.
- R3: The move-class kind is in bits 14:13 and needs bit 15 = 0. Kind 00 is a move that always executes, whatever bits 9:8 hold. A move writes the immediate (bits 7:0) to the destination in bits 12:10 during phase 7, with wrEn high, wrSel = destination and wrData = immediate.
- R4: A move or call whose destination is 7 never raises wrEn. Instead the next instruction is fetched from the immediate address.
- R5: Kind 01 is a call. When it executes, phase 6 writes the link register (wrSel = 6) with the program counter plus one. Phase 7 then performs the move to its destination.
- R6: Kinds 01 and 10 execute only if the condition in bits 9:8 holds: 00 always, 01 zero flag set, 10 zero flag clear, 11 negative flag set. A failed instruction makes no write, and the program counter advances by one.
- R7: Bit 15 = 1 marks an ALU instruction. rdSelA takes bits 7:4 and rdSelB takes bits 3:0, rdEn is high in phases 2 to 4, aluOp carries bits 14:12, and aluGo pulses in phase 3 only.
- R8: The flags are bit 0 zero, bit 1 negative and bit 2 overflow. They load from aluFlagsIn at the edge that leaves phase 4, and only for ALU instructions. Move-class instructions leave them unchanged.
- R9: In phase 5 an ALU instruction writes the result captured in phase 4 to the destination in bits 11:9, unless bit 8 (no-write) is set. Destination 7 loads the program counter instead of raising wrEn.
- R10: Kind 11 is a no-op. It makes no write and does not change the flags, and the program counter advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | ADDR_W | Program counter driven to program memory |
| memData | input | 16 | Instruction word from program memory |
| rdEn | output | 1 | Register-file read enable for ALU operands |
| rdSelA | output | SEL_W | First operand register select |
| rdSelB | output | SEL_W | Second operand register select |
| aluOp | output | 3 | ALU operation select |
| aluGo | output | 1 | ALU start strobe |
| aluResult | input | DATA_W | Result from the ALU |
| aluFlagsIn | input | 3 | Flags from the ALU: overflow, negative, zero |
| wrEn | output | 1 | Register-file write enable |
| wrSel | output | 3 | Register-file write select |
| wrData | output | DATA_W | Register-file write data |
| flags | output | 3 | Latched flags: overflow, negative, zero |
| phase | output | 4 | Current phase of the schedule |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data and 4-bit operand selects. With those defaults an immediate spans the whole address space, so jumps and calls to high addresses, and the link value taken next to them, are all reachable. Under these settings the scoreboard tracks every write with its phase, select and data. It covers taken and skipped branches for each condition code, ALU results aimed at the program counter, the compare form, and a reset asserted partway through an instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int INSTR_W    = 16;
  localparam int IMM_W      = 8;
  localparam int NUM_PHASES = 10;
  localparam int PHASE_W    = $clog2(NUM_PHASES);

  // Fixed positions in the schedule
  localparam int PH_FETCH    = 0;
  localparam int PH_COND     = 1;
  localparam int PH_RD_FIRST = 2;
  localparam int PH_ALU_GO   = 3;
  localparam int PH_CAPTURE  = 4;
  localparam int PH_RD_LAST  = PH_CAPTURE;
  localparam int PH_ALU_WB   = 5;
  localparam int PH_LINK_WB  = 6;
  localparam int PH_MOV_WB   = 7;
  localparam int PH_PC_STEP  = NUM_PHASES - 1;

  localparam logic [2:0] REG_LINK = 3'd6;
  localparam logic [2:0] REG_PC   = 3'd7;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_V = 2;

  typedef enum logic [1:0] {
    KIND_MOVE  = 2'b00,
    KIND_CALL  = 2'b01,
    KIND_CMOVE = 2'b10,
    KIND_NOP   = 2'b11
  } moveKind_e;

  typedef enum logic [1:0] {
    COND_ALWAYS  = 2'b00,
    COND_ZERO    = 2'b01,
    COND_NONZERO = 2'b10,
    COND_NEG     = 2'b11
  } cond_e;

  // Strobes from the phase sequencer to the datapath
  typedef struct packed {
    logic fetch;
    logic evalCond;
    logic readOps;
    logic aluGo;
    logic capture;
    logic aluWb;
    logic linkWb;
    logic movWb;
    logic pcStep;
  } strobes_t;

  typedef struct packed {
    logic            isAlu;
    moveKind_e       kind;
    logic [2:0]      movDest;
    cond_e           cond;
    logic [IMM_W-1:0] imm;
    logic [2:0]      aluOp;
    logic [2:0]      aluDest;
    logic            noWrite;
    logic [3:0]      srcA;
    logic [3:0]      srcB;
  } decoded_t;

  function automatic decoded_t decodeWord(input logic [INSTR_W-1:0] w);
    decoded_t d;
    d.isAlu   = w[15];
    d.kind    = moveKind_e'(w[14:13]);
    d.movDest = w[12:10];
    d.cond    = cond_e'(w[9:8]);
    d.imm     = w[7:0];
    d.aluOp   = w[14:12];
    d.aluDest = w[11:9];
    d.noWrite = w[8];
    d.srcA    = w[7:4];
    d.srcB    = w[3:0];
    return d;
  endfunction

  function automatic logic condHolds(input cond_e c, input logic [2:0] f);
    logic ok;
    case (c)
      COND_ALWAYS:  ok = 1'b1;
      COND_ZERO:    ok = f[FLAG_Z];
      COND_NONZERO: ok = ~f[FLAG_Z];
      default:      ok = f[FLAG_N];
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase,
  output strobes_t           strobes
);

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(NUM_PHASES - 1);

  logic [PHASE_W-1:0] phaseQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
    end else if (phaseQ == LAST) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + PHASE_W'(1);
    end
  end

  function automatic logic atPhase(input logic [PHASE_W-1:0] p, input int n);
    return p == PHASE_W'(n);
  endfunction

  always_comb begin
    strobes          = '0;
    strobes.fetch    = atPhase(phaseQ, PH_FETCH);
    strobes.evalCond = atPhase(phaseQ, PH_COND);
    strobes.readOps  = (phaseQ >= PHASE_W'(PH_RD_FIRST)) &&
                       (phaseQ <= PHASE_W'(PH_RD_LAST));
    strobes.aluGo    = atPhase(phaseQ, PH_ALU_GO);
    strobes.capture  = atPhase(phaseQ, PH_CAPTURE);
    strobes.aluWb    = atPhase(phaseQ, PH_ALU_WB);
    strobes.linkWb   = atPhase(phaseQ, PH_LINK_WB);
    strobes.movWb    = atPhase(phaseQ, PH_MOV_WB);
    strobes.pcStep   = atPhase(phaseQ, PH_PC_STEP);
  end

  assign phase = phaseQ;

endmodule

// File: rtl/seq_path.sv
module seq_path
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic [INSTR_W-1:0] memData,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic [2:0]         aluFlagsIn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               rdEn,
  output logic [SEL_W-1:0]   rdSelA,
  output logic [SEL_W-1:0]   rdSelB,
  output logic [2:0]         aluOp,
  output logic               aluGo,
  output logic               wrEn,
  output logic [2:0]         wrSel,
  output logic [DATA_W-1:0]  wrData,
  output logic [2:0]         flags
);

  logic [INSTR_W-1:0] instrQ;
  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pcPlusOne;
  logic [2:0]         flagsQ;
  logic [DATA_W-1:0]  resultQ;
  logic               condOkQ;
  logic               jumpPendQ;
  logic [ADDR_W-1:0]  jumpTgtQ;

  decoded_t dec;
  logic     passNow;
  logic     aluWbFire;
  logic     linkFire;
  logic     movFire;

  assign dec       = decodeWord(instrQ);
  assign pcPlusOne = pcQ + ADDR_W'(1);

  // Whether the instruction in the register is allowed to write
  always_comb begin
    if (dec.isAlu) begin
      passNow = 1'b1;
    end else begin
      case (dec.kind)
        KIND_MOVE: passNow = 1'b1;
        KIND_NOP:  passNow = 1'b0;
        default:   passNow = condHolds(dec.cond, flagsQ);
      endcase
    end
  end

  assign aluWbFire = strobes.aluWb  &&  dec.isAlu && condOkQ && !dec.noWrite;
  assign linkFire  = strobes.linkWb && !dec.isAlu && condOkQ && (dec.kind == KIND_CALL);
  assign movFire   = strobes.movWb  && !dec.isAlu && condOkQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      instrQ    <= '0;
      pcQ       <= '0;
      flagsQ    <= '0;
      resultQ   <= '0;
      condOkQ   <= 1'b0;
      jumpPendQ <= 1'b0;
      jumpTgtQ  <= '0;
    end else begin
      if (strobes.fetch) begin
        instrQ <= memData;
      end
      if (strobes.evalCond) begin
        condOkQ <= passNow;
      end
      if (strobes.capture && dec.isAlu) begin
        flagsQ  <= aluFlagsIn;
        resultQ <= aluResult;
      end
      if (aluWbFire && (dec.aluDest == REG_PC)) begin
        jumpPendQ <= 1'b1;
        jumpTgtQ  <= ADDR_W'(resultQ);
      end
      if (movFire && (dec.movDest == REG_PC)) begin
        jumpPendQ <= 1'b1;
        jumpTgtQ  <= ADDR_W'(dec.imm);
      end
      if (strobes.pcStep) begin
        pcQ       <= jumpPendQ ? jumpTgtQ : pcPlusOne;
        jumpPendQ <= 1'b0;
      end
    end
  end

  // Register-file write port
  always_comb begin
    wrEn   = 1'b0;
    wrSel  = '0;
    wrData = '0;
    if (aluWbFire) begin
      wrEn   = (dec.aluDest != REG_PC);
      wrSel  = dec.aluDest;
      wrData = resultQ;
    end else if (linkFire) begin
      wrEn   = 1'b1;
      wrSel  = REG_LINK;
      wrData = DATA_W'(pcPlusOne);
    end else if (movFire) begin
      wrEn   = (dec.movDest != REG_PC);
      wrSel  = dec.movDest;
      wrData = DATA_W'(dec.imm);
    end
  end

  assign rdEn    = strobes.readOps && dec.isAlu;
  assign rdSelA  = SEL_W'(dec.srcA);
  assign rdSelB  = SEL_W'(dec.srcB);
  assign aluOp   = dec.aluOp;
  assign aluGo   = strobes.aluGo && dec.isAlu;
  assign memAddr = pcQ;
  assign flags   = flagsQ;

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [INSTR_W-1:0] memData,
  output logic               rdEn,
  output logic [SEL_W-1:0]   rdSelA,
  output logic [SEL_W-1:0]   rdSelB,
  output logic [2:0]         aluOp,
  output logic               aluGo,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic [2:0]         aluFlagsIn,
  output logic               wrEn,
  output logic [2:0]         wrSel,
  output logic [DATA_W-1:0]  wrData,
  output logic [2:0]         flags,
  output logic [PHASE_W-1:0] phase
);

  strobes_t strobes;

  seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .strobes (strobes)
  );

  seq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .memData    (memData),
    .aluResult  (aluResult),
    .aluFlagsIn (aluFlagsIn),
    .memAddr    (memAddr),
    .rdEn       (rdEn),
    .rdSelA     (rdSelA),
    .rdSelB     (rdSelB),
    .aluOp      (aluOp),
    .aluGo      (aluGo),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .flags      (flags)
  );

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               rdEn,
  input logic               aluGo,
  input logic               wrEn,
  input logic [2:0]         wrSel,
  input logic [2:0]         flags,
  input logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(NUM_PHASES - 1);

  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST) |=> (phase == $past(phase) + PHASE_W'(1)));

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST) |=> (phase == '0));

  a_r1_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST) |=> $stable(memAddr));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PHASE_W'(PH_CAPTURE)) |=> $stable(flags));

  a_r7_go_phase: assert property (@(posedge clk) disable iff (rst)
    aluGo |-> (phase == PHASE_W'(PH_ALU_GO)));

  a_r7_read_window: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (phase >= PHASE_W'(PH_RD_FIRST) && phase <= PHASE_W'(PH_RD_LAST)));

  a_r3_write_window: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (phase >= PHASE_W'(PH_ALU_WB) && phase <= PHASE_W'(PH_MOV_WB)));

  a_r5_link_select: assert property (@(posedge clk) disable iff (rst)
    (wrEn && phase == PHASE_W'(PH_LINK_WB)) |-> (wrSel == REG_LINK));

  a_r4_no_pc_strobe: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (wrSel != REG_PC));

  a_r2_quiet_in_reset: assert property (@(posedge clk)
    rst |=> !(wrEn || rdEn || aluGo) || !rst);

endmodule

bind seq_core seq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .memAddr (memAddr),
  .rdEn    (rdEn),
  .aluGo   (aluGo),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .flags   (flags),
  .phase   (phase)
);

// File: tb/sim_seq_core.sv
module sim_seq_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  memAddr;
  logic [15:0] memData = '0;
  logic        rdEn;
  logic [3:0]  rdSelA, rdSelB;
  logic [2:0]  aluOp;
  logic        aluGo;
  logic [7:0]  aluResult = '0;
  logic [2:0]  aluFlagsIn = '0;
  logic        wrEn;
  logic [2:0]  wrSel;
  logic [7:0]  wrData;
  logic [2:0]  flags;
  logic [3:0]  phase;

  always #10 clk = ~clk;

  seq_core u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memData(memData),
    .rdEn(rdEn), .rdSelA(rdSelA), .rdSelB(rdSelB), .aluOp(aluOp),
    .aluGo(aluGo), .aluResult(aluResult), .aluFlagsIn(aluFlagsIn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .flags(flags),
    .phase(phase)
  );

  typedef struct {
    int    ph;
    int    sel;
    int    data;
    string tag;
  } item_t;

  item_t  expQ[$];
  int     nChecks = 0;
  int     nFail   = 0;
  bit     done    = 0;
  logic [7:0] expPc;
  logic [2:0] expFlags;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expectWrite(input int ph, input int sel, input int data, input string tag);
    item_t it;
    it.ph = ph; it.sel = sel; it.data = data; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: every write strobe must match the oldest expected item
  always @(negedge clk) begin
    if (!rst && wrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected write sel", int'(wrSel), -1);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(int'(phase) == it.ph,    it.tag, "write phase", int'(phase), it.ph);
        check(int'(wrSel) == it.sel,   it.tag, "write sel",   int'(wrSel), it.sel);
        check(int'(wrData) == it.data, it.tag, "write data",  int'(wrData), it.data);
      end
    end
  end

  // Starts and ends on a falling edge with phase 0
  task automatic execInstr(input logic [15:0] ins, input logic [7:0] res,
                           input logic [2:0] fl);
    memData    = ins;
    aluResult  = res;
    aluFlagsIn = fl;
    repeat (10) @(negedge clk);
  endtask

  task automatic checkState(input string tag);
    check(expQ.size() == 0, tag, "pending writes", expQ.size(), 0);
    check(phase == 4'd0, tag, "phase at boundary", int'(phase), 0);
    check(memAddr == expPc, tag, "pc", int'(memAddr), int'(expPc));
    check(flags == expFlags, tag, "flags", int'(flags), int'(expFlags));
    expQ.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(phase == 4'd0, "R2", "phase", int'(phase), 0);
    check(memAddr == 8'd0, "R2", "pc", int'(memAddr), 0);
    check(flags == 3'd0, "R2", "flags", int'(flags), 0);
    check(!(wrEn || rdEn || aluGo), "R2", "strobes", int'({wrEn, rdEn, aluGo}), 0);
    rst = 1'b0;
    expPc = 8'd0;
    expFlags = 3'd0;

    // R3 plain move to reg 0
    expectWrite(7, 0, 'h5A, "R3");
    execInstr(16'h005A, 8'h00, 3'd0);
    expPc = 8'd1; checkState("R3");

    // R3 kind 00 ignores its condition field (zero test, zero flag clear)
    expectWrite(7, 2, 'h33, "R3");
    execInstr(16'h0933, 8'h00, 3'd0);
    expPc = 8'd2; checkState("R3");

    // R7 R9 ALU op 3, dest 1, sources 4 and 5; probe in phase 3
    expectWrite(5, 1, 'h80, "R9");
    memData = 16'hB245; aluResult = 8'h80; aluFlagsIn = 3'b010;
    repeat (3) @(negedge clk);
    check(phase == 4'd3, "R1", "phase count", int'(phase), 3);
    check(aluGo == 1'b1, "R7", "aluGo", int'(aluGo), 1);
    check(rdEn == 1'b1, "R7", "rdEn", int'(rdEn), 1);
    check(rdSelA == 4'd4, "R7", "rdSelA", int'(rdSelA), 4);
    check(rdSelB == 4'd5, "R7", "rdSelB", int'(rdSelB), 5);
    check(aluOp == 3'd3, "R7", "aluOp", int'(aluOp), 3);
    check(memAddr == expPc, "R1", "pc mid-instruction", int'(memAddr), int'(expPc));
    repeat (7) @(negedge clk);
    expPc = 8'd3; expFlags = 3'b010; checkState("R8");

    // R9 no-write bit: flags update, nothing written
    execInstr(16'h9501, 8'h00, 3'b001);
    expPc = 8'd4; expFlags = 3'b001; checkState("R9");

    // R6 conditional move on zero, taken
    expectWrite(7, 3, 'h11, "R6");
    execInstr(16'h4D11, 8'hFF, 3'b111);
    expPc = 8'd5; checkState("R6");

    // R6 conditional move on not-zero, skipped
    execInstr(16'h4E22, 8'h00, 3'd0);
    expPc = 8'd6; checkState("R6");

    // R6 conditional move on negative, skipped
    execInstr(16'h5344, 8'h00, 3'd0);
    expPc = 8'd7; checkState("R6");

    // R4 jump: move to destination 7
    execInstr(16'h1C40, 8'h00, 3'd0);
    expPc = 8'h40; checkState("R4");

    // R5 call to 0x80, link gets 0x41
    expectWrite(6, 6, 'h41, "R5");
    execInstr(16'h3C80, 8'h00, 3'd0);
    expPc = 8'h80; checkState("R5");

    // R6 call on not-zero with zero flag set: skipped
    execInstr(16'h3E10, 8'h00, 3'd0);
    expPc = 8'h81; checkState("R6");

    // R10 reserved kind is a no-op
    execInstr(16'h60FF, 8'h55, 3'b110);
    expPc = 8'h82; checkState("R10");

    // R9 ALU result into PC
    execInstr(16'h8E23, 8'h10, 3'b100);
    expPc = 8'h10; expFlags = 3'b100; checkState("R9");

    // R8 compare sets negative, then R6 conditional move on negative taken
    execInstr(16'hA100, 8'h00, 3'b010);
    expPc = 8'h11; expFlags = 3'b010; checkState("R8");
    expectWrite(7, 5, 'h99, "R6");
    execInstr(16'h5799, 8'h00, 3'd0);
    expPc = 8'h12; checkState("R6");

    // R2 reset partway through an instruction
    memData = 16'h005A;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(memAddr == 8'd0, "R2", "pc after reset", int'(memAddr), 0);
    check(flags == 3'd0, "R2", "flags after reset", int'(flags), 0);
    check(phase == 4'd0, "R2", "phase after reset", int'(phase), 0);
    rst = 1'b0;
    expPc = 8'd0; expFlags = 3'd0;
    expQ.delete();
    expectWrite(7, 0, 'h5A, "R3");
    execInstr(16'h005A, 8'h00, 3'd0);
    expPc = 8'd1; checkState("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule